// File: doc/BRIEF.md
# General-Purpose Pin Control over AXI4-Lite

This block is a 32-bit AXI4-Lite slave with eight word registers that lets software operate a small group of pins. It drives four dedicated output pins and reads back four dedicated input pins. It also controls four bidirectional pins, each with its own drive value and direction bit. The bidirectional pins are presented as three separate vectors: the level seen at the pad, the value to drive, and a tristate control. The pad buffer itself sits outside the block.

Input levels are captured through one register stage on every clock and can be read at fixed offsets. A constant identification word lets software confirm that the block is present before it touches any pins. Writable locations honour byte strobes. Writes aimed at read-only locations complete normally on the bus but change nothing.

Top module: `pin_ctrl_axil`

## Requirements
- R1: Offset 0x1C always reads 0xDECADE90, including after a write of any value to it.
- R2: Offset 0x04 reads 28 zero bits above the four dedicated input pins (pin n at bit n), sampled through one register stage.
- R3: Offset 0x10 reads 28 zero bits above the four bidirectional pin input levels (pin n at bit n), sampled through one register stage.
- R4: A write to 0x04, 0x10 or 0x1C completes with an OKAY response and leaves the value read back from that offset unchanged.
- R5: `out_pins[3:0]` always equals bits [3:0] of the register at 0x00.
- R6: `io_tri[3:0]` equals bits [3:0] of the register at 0x08 and `io_drv[3:0]` equals bits [3:0] of the register at 0x0C. A tristate bit of 1 releases the pin, and 0 makes it drive its `io_drv` bit.
- R7: A write to a writable register changes only the byte lanes whose WSTRB bit is set (lane k covers bits 8k+7 down to 8k).
- R8: While `aresetn` is low, every writable register clears to zero, so the outputs read zero and all bidirectional pins drive 0.
- R9: Each write accepts its address and data once, in either order, and returns exactly one response with BRESP = 0 (OKAY). The response stays valid and unchanged until BREADY is high, and no new address or data is accepted while it waits.
- R10: Each read returns RRESP = 0 with RDATA held stable while RVALID is high and RREADY is low. No new read address is accepted during that time.
- R11: Offsets 0x14 and 0x18 act as plain storage and read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 5 | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 5 | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| in_pins | input | 4 | Dedicated input pins |
| out_pins | output | 4 | Dedicated output pins |
| io_in | input | 4 | Level seen at each bidirectional pin |
| io_drv | output | 4 | Value driven on each bidirectional pin |
| io_tri | output | 4 | Tristate control, 1 = released |

## Verification
The assertions assume that the master follows AXI4-Lite. Once a valid is raised, the master holds it and its payload until ready. Addresses are word-aligned. The master never depends on a combinational path from valid to ready. The bench keeps to these rules by driving every channel from tasks on the falling edge, holding each valid until the handshake is seen, and issuing only aligned offsets. To exercise the hold behaviour, it delays BREADY and RREADY and it presents the address and data channels in both orders. The bench models the external pins as the drive value when a pin is driven and as a bench-chosen level when it is released.

// File: rtl/pin_ctrl_axil.sv
module pin_ctrl_axil #(
  parameter int          PIN_W   = 4,
  parameter logic [31:0] ID_WORD = 32'hDECADE90
) (
  input  logic             aclk,
  input  logic             aresetn,
  input  logic [4:0]       s_awaddr,
  input  logic             s_awvalid,
  output logic             s_awready,
  input  logic [31:0]      s_wdata,
  input  logic [3:0]       s_wstrb,
  input  logic             s_wvalid,
  output logic             s_wready,
  output logic [1:0]       s_bresp,
  output logic             s_bvalid,
  input  logic             s_bready,
  input  logic [4:0]       s_araddr,
  input  logic             s_arvalid,
  output logic             s_arready,
  output logic [31:0]      s_rdata,
  output logic [1:0]       s_rresp,
  output logic             s_rvalid,
  input  logic             s_rready,
  input  logic [PIN_W-1:0] in_pins,
  output logic [PIN_W-1:0] out_pins,
  input  logic [PIN_W-1:0] io_in,
  output logic [PIN_W-1:0] io_drv,
  output logic [PIN_W-1:0] io_tri
);
  localparam int DW   = 32;
  localparam int NB   = DW / 8;
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);

  localparam logic [IW-1:0] IDX_OUT = 3'd0;
  localparam logic [IW-1:0] IDX_IN  = 3'd1;
  localparam logic [IW-1:0] IDX_DIR = 3'd2;
  localparam logic [IW-1:0] IDX_DRV = 3'd3;
  localparam logic [IW-1:0] IDX_IO  = 3'd4;
  localparam logic [IW-1:0] IDX_ID  = 3'd7;

  logic [DW-1:0]    regs_q [NREG];
  logic [PIN_W-1:0] in_q, io_q;

  logic            aw_held, w_held;
  logic [IW-1:0]   aw_idx_q;
  logic [DW-1:0]   w_data_q;
  logic [NB-1:0]   w_strb_q;
  logic            wr_fire;
  logic            wr_ok;

  logic unused_lsb;
  assign unused_lsb = ^{s_awaddr[1:0], s_araddr[1:0]};

  assign s_awready = !aw_held && !s_bvalid;
  assign s_wready  = !w_held  && !s_bvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign s_arready = !s_rvalid;

  assign wr_fire = aw_held && w_held && !s_bvalid;
  assign wr_ok   = !(aw_idx_q == IDX_IN || aw_idx_q == IDX_IO || aw_idx_q == IDX_ID);

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      in_q <= '0;
      io_q <= '0;
    end else begin
      in_q <= in_pins;
      io_q <= io_in;
    end
  end

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      aw_idx_q <= '0;
      w_data_q <= '0;
      w_strb_q <= '0;
      s_bvalid <= 1'b0;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_held  <= 1'b1;
        aw_idx_q <= s_awaddr[4:2];
      end
      if (s_wvalid && s_wready) begin
        w_held   <= 1'b1;
        w_data_q <= s_wdata;
        w_strb_q <= s_wstrb;
      end
      if (wr_fire) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        s_bvalid <= 1'b1;
      end else if (s_bvalid && s_bready) begin
        s_bvalid <= 1'b0;
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge aclk) begin
      if (!aresetn) begin
        regs_q[r] <= '0;
      end else if (wr_fire && wr_ok && aw_idx_q == IW'(r)) begin
        for (int b = 0; b < NB; b++)
          if (w_strb_q[b]) regs_q[r][8*b +: 8] <= w_data_q[8*b +: 8];
      end
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (s_araddr[4:2])
      IDX_IN:  rd_mux = {{(DW-PIN_W){1'b0}}, in_q};
      IDX_IO:  rd_mux = {{(DW-PIN_W){1'b0}}, io_q};
      IDX_ID:  rd_mux = ID_WORD;
      default: rd_mux = regs_q[s_araddr[4:2]];
    endcase
  end

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (s_arvalid && s_arready) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_mux;
    end else if (s_rvalid && s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  assign out_pins = regs_q[IDX_OUT][PIN_W-1:0];
  assign io_tri   = regs_q[IDX_DIR][PIN_W-1:0];
  assign io_drv   = regs_q[IDX_DRV][PIN_W-1:0];
endmodule

// File: rtl/pin_ctrl_axil_chk.sv
module pin_ctrl_axil_chk #(
  parameter int PIN_W = 4
) (
  input logic             aclk,
  input logic             aresetn,
  input logic             s_awready,
  input logic             s_wready,
  input logic [1:0]       s_bresp,
  input logic             s_bvalid,
  input logic             s_bready,
  input logic             s_arready,
  input logic [31:0]      s_rdata,
  input logic [1:0]       s_rresp,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [PIN_W-1:0] out_pins,
  input logic [PIN_W-1:0] io_drv,
  input logic [PIN_W-1:0] io_tri,
  input logic             wr_fire
);
  a_r9_bresp_okay: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> s_bresp == 2'b00);
  a_r9_bvalid_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);
  a_r9_no_accept_while_resp: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> !s_awready && !s_wready);
  a_r10_rdata_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  a_r10_rresp_okay: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> s_rresp == 2'b00);
  a_r10_no_ar_while_rvalid: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> !s_arready);
  a_r5_out_quiet: assert property (@(posedge aclk) disable iff (!aresetn)
    !wr_fire |=> $stable(out_pins));
  a_r6_bidir_quiet: assert property (@(posedge aclk) disable iff (!aresetn)
    !wr_fire |=> $stable(io_tri) && $stable(io_drv));
endmodule

bind pin_ctrl_axil pin_ctrl_axil_chk #(.PIN_W(PIN_W)) u_chk (
  .aclk(aclk), .aresetn(aresetn), .s_awready(s_awready), .s_wready(s_wready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_arready(s_arready), .s_rdata(s_rdata), .s_rresp(s_rresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .out_pins(out_pins),
  .io_drv(io_drv), .io_tri(io_tri), .wr_fire(wr_fire)
);

// File: tb/pin_ctrl_axil_tb.sv
module pin_ctrl_axil_tb;
  logic aclk = 0, aresetn = 0;
  always #4 aclk = ~aclk;

  logic [4:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [3:0] in_pins = 0, ext = 0, out_pins, io_drv, io_tri, io_in;

  assign io_in = (io_tri & ext) | (~io_tri & io_drv);

  pin_ctrl_axil u_dut (
    .aclk(aclk), .aresetn(aresetn),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .in_pins(in_pins), .out_pins(out_pins), .io_in(io_in),
    .io_drv(io_drv), .io_tri(io_tri));

  int checks = 0, errors = 0;
  logic [31:0] model [8];
  int pend_idx;
  logic [31:0] pend_data;
  logic [3:0] pend_strb;
  logic prev_b = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int idx);
    case (idx)
      1: return {28'b0, in_pins};
      4: return {28'b0, (model[2][3:0] & ext) | (~model[2][3:0] & model[3][3:0])};
      7: return 32'hDECADE90;
      default: return model[idx];
    endcase
  endfunction

  initial for (int i = 0; i < 8; i++) model[i] = 0;

  always @(negedge aclk) begin
    if (aresetn) begin
      if (bvalid && !prev_b && !(pend_idx == 1 || pend_idx == 4 || pend_idx == 7))
        for (int b = 0; b < 4; b++)
          if (pend_strb[b]) model[pend_idx][8*b +: 8] = pend_data[8*b +: 8];
      chk("R5 out_pins", {28'b0, out_pins}, {28'b0, model[0][3:0]});
      chk("R6 io_tri", {28'b0, io_tri}, {28'b0, model[2][3:0]});
      chk("R6 io_drv", {28'b0, io_drv}, {28'b0, model[3][3:0]});
    end
    prev_b = bvalid;
  end

  task automatic send_aw();
    awvalid = 1;
    while (awvalid) begin
      automatic logic hs = awready;
      @(negedge aclk);
      if (hs) awvalid = 0;
    end
  endtask

  task automatic send_w();
    wvalid = 1;
    while (wvalid) begin
      automatic logic hs = wready;
      @(negedge aclk);
      if (hs) wvalid = 0;
    end
  endtask

  task automatic wr(int idx, logic [31:0] d, logic [3:0] s, int order, int bdly);
    pend_idx = idx; pend_data = d; pend_strb = s;
    @(negedge aclk);
    awaddr = 5'(idx * 4); wdata = d; wstrb = s;
    if (order == 1) begin send_aw(); send_w(); end
    else if (order == 2) begin send_w(); send_aw(); end
    else begin
      awvalid = 1; wvalid = 1;
      while (awvalid || wvalid) begin
        automatic logic ha = awvalid && awready;
        automatic logic hw = wvalid && wready;
        @(negedge aclk);
        if (ha) awvalid = 0;
        if (hw) wvalid = 0;
      end
    end
    repeat (bdly) @(negedge aclk);
    while (!bvalid) @(negedge aclk);
    if (bdly > 0) chk("R9 bvalid held", {31'b0, bvalid}, 32'd1);
    chk("R9 bresp", {30'b0, bresp}, 32'd0);
    bready = 1;
    @(negedge aclk);
    bready = 0;
    chk("R9 single response", {31'b0, bvalid}, 32'd0);
  endtask

  task automatic rd(int idx, int rdly, string tag);
    logic [31:0] first;
    @(negedge aclk);
    araddr = 5'(idx * 4); arvalid = 1;
    while (arvalid) begin
      automatic logic hs = arready;
      @(negedge aclk);
      if (hs) arvalid = 0;
    end
    while (!rvalid) @(negedge aclk);
    first = rdata;
    repeat (rdly) @(negedge aclk);
    if (rdly > 0) chk("R10 rdata held", rdata, first);
    chk(tag, rdata, exp_read(idx));
    chk("R10 rresp", {30'b0, rresp}, 32'd0);
    rready = 1;
    @(negedge aclk);
    rready = 0;
  endtask

  initial begin
    repeat (3) @(negedge aclk);
    chk("R8 out_pins in reset", {28'b0, out_pins}, 32'd0);
    chk("R8 io_tri in reset", {28'b0, io_tri}, 32'd0);
    chk("R8 io_drv in reset", {28'b0, io_drv}, 32'd0);
    aresetn = 1;
    @(negedge aclk);
    rd(0, 0, "R8 reg 0x00 after reset");
    rd(2, 0, "R8 reg 0x08 after reset");
    rd(7, 0, "R1 ID word");

    wr(0, 32'h7, 4'hF, 0, 0);
    rd(0, 0, "R5 reg 0x00");
    wr(0, 32'h8, 4'hF, 1, 2);
    wr(0, 32'hFF, 4'b0010, 2, 0);
    rd(0, 0, "R7 masked lane on 0x00");

    in_pins = 4'h9; repeat (3) @(negedge aclk);
    rd(1, 0, "R2 inputs 9");
    in_pins = 4'h6; repeat (3) @(negedge aclk);
    rd(1, 2, "R2 inputs 6");

    wr(3, 32'hF, 4'hF, 0, 0);
    wr(2, 32'h0, 4'hF, 0, 0);
    repeat (2) @(negedge aclk);
    rd(4, 0, "R3 bidir all driven");
    ext = 4'hA;
    wr(2, 32'hF, 4'hF, 0, 0);
    repeat (2) @(negedge aclk);
    rd(4, 0, "R3 bidir all released");
    wr(2, 32'h3, 4'hF, 1, 0);
    wr(3, 32'h5, 4'hF, 2, 1);
    repeat (2) @(negedge aclk);
    rd(4, 0, "R6 bidir mixed direction");

    wr(1, 32'hFFFF_FFFF, 4'hF, 0, 0);
    rd(1, 0, "R4 write to 0x04 ignored");
    wr(4, 32'hFFFF_FFFF, 4'hF, 0, 0);
    rd(4, 0, "R4 write to 0x10 ignored");
    wr(7, 32'h0, 4'hF, 0, 0);
    rd(7, 0, "R4 R1 write to 0x1C ignored");

    wr(5, 32'h1122_3344, 4'hF, 0, 0);
    rd(5, 0, "R11 reserved 0x14 storage");
    wr(5, 32'hAABB_CCDD, 4'b0101, 0, 0);
    rd(5, 3, "R7 partial strobe 0x14");
    wr(6, 32'hCAFE_0001, 4'b1000, 1, 0);
    rd(6, 0, "R11 R7 reserved 0x18");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge aclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule